// File: doc/BRIEF.md
# Platform System-Controller Register Block

This block is the register window of a development platform's system controller. Software reads fixed status and configuration words from it. These cover the build identifiers, memory-interface health, which PCIe ports were built in, the installed memory size and the clock-generator settings. Software also writes to it to ask for a full system reset. The reset sequencer, clock generators and memory controller live elsewhere. Their state reaches this block as input pins or as parameters.

Every request is a single-cycle strobe with an address, a byte count and, for writes, data. Only whole 32-bit accesses are serviced, and only the low 16 address bits select a register. The response to a read, the reset-request pulse and a debug flag for accesses the block does not implement are all registered. All three appear one clock after the request.

Top module: `plat_sysctl_regs`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid`, `rsp_rdata`, `sys_reset_req` and `unimpl_access` are all zero.
- R2: A read request (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 exactly one cycle later. A write, or an idle cycle, gives `rsp_valid`=0 and `rsp_rdata`=0 in the following cycle.
- R3: A request whose `req_size` is not 4 behaves as follows. A read returns zero. A write changes nothing and gives no reset pulse. Either kind raises `unimpl_access` for one cycle.
- R4: Register decode looks only at `req_addr[15:0]`, so address bits 31..16 have no effect.
- R5: Offsets 0x00, 0x04 and 0x08 read as 0x00000000.
- R6: Offset 0x14 (memory-interface status) reads 0x00000005, which means bit 0 (locked) and bit 2 (calibrated) are set.
- R7: Offset 0x30 (clock-generator descriptor) packs four fields: the output-0 divider in bits [7:0], the input frequency in whole MHz in bits [15:8], the feedback multiplier in bits [23:16] and the output-1 divider in bits [31:24]. The MHz value is `timer_hz` divided by 1,000,000, truncated, with its low 8 bits kept. By default the divider and multiplier fields each read 1.
- R8: Offset 0x34 (build configuration) reads 0x0000000E. Bits 1, 2 and 3 are set (three PCIe ports present), and bit 0 (coherence unit) is clear.
- R9: Offset 0x38 (memory configuration) reads `mem_gib` in bits [3:0] with bits [15:4] all ones, and zero above bit 15.
- R10: A 32-bit write to offset 0x10 with data bit 4 set raises `sys_reset_req` for exactly one cycle, one cycle later. If bit 4 is clear, there is no pulse and no flag.
- R11: 32-bit writes to offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are ignored without raising `unimpl_access`. Later reads return the same values as before.
- R12: Any other 32-bit access reads zero and raises `unimpl_access` for one cycle. This includes reads of 0x0C, 0x10, 0x18, 0x1C–0x2C and 0x3C–0x48, writes to 0x0C and to 0x1C upward except the listed ones, and any offset that is not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits [15:0] decoded |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| timer_hz | input | 32 | Live timer reference frequency in Hz |
| mem_gib | input | 4 | Installed memory size in GiB |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| unimpl_access | output | 1 | One-cycle flag for an unserviced access |

## Verification
Every result (read data with its valid, the reset pulse and the unimplemented flag) is due in the cycle right after the edge that accepts the request. It is driven in the same register stage, so nothing arrives two cycles later. The bench drives each request on a falling edge and samples all four outputs on the next falling edge, half a period after that rising edge. It then checks the cycle after that to confirm that every pulse has dropped again.

// File: rtl/plat_sysctl_regs.sv
module plat_sysctl_regs #(
  parameter int unsigned HZ_PER_MHZ = 1000000,
  parameter logic [7:0]  CLK0_DIV   = 8'd1,
  parameter logic [7:0]  FB_MUL     = 8'd1,
  parameter logic [7:0]  CLK1_DIV   = 8'd1,
  parameter logic [11:0] DDR_MHZ    = 12'hFFF,
  parameter logic [3:0]  BUILD_CFG  = 4'hE,
  parameter int unsigned RST_BIT    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic [31:0] timer_hz,
  input  logic [3:0]  mem_gib,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        sys_reset_req,
  output logic        unimpl_access
);
  localparam logic [15:0] A_BUILD  = 16'h0000;
  localparam logic [15:0] A_CORECL = 16'h0004;
  localparam logic [15:0] A_WRAPCL = 16'h0008;
  localparam logic [15:0] A_SRST   = 16'h0010;
  localparam logic [15:0] A_MEMST  = 16'h0014;
  localparam logic [15:0] A_PCIEST = 16'h0018;
  localparam logic [15:0] A_CLKGEN = 16'h0030;
  localparam logic [15:0] A_BCFG   = 16'h0034;
  localparam logic [15:0] A_MCFG   = 16'h0038;

  logic [15:0] off;
  logic        word_ok, rd_req, wr_req;
  logic [7:0]  in_mhz;
  logic        rd_hit, wr_hit;
  logic [31:0] rd_val;

  assign off     = req_addr[15:0];
  assign word_ok = (req_size == 4'd4);
  assign rd_req  = req_valid & ~req_write;
  assign wr_req  = req_valid &  req_write;
  assign in_mhz  = 8'(timer_hz / HZ_PER_MHZ);

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    case (off)
      A_BUILD, A_CORECL, A_WRAPCL: rd_val = '0;
      A_MEMST:  rd_val = 32'h0000_0005;
      A_CLKGEN: rd_val = {CLK1_DIV, FB_MUL, in_mhz, CLK0_DIV};
      A_BCFG:   rd_val = {28'd0, BUILD_CFG};
      A_MCFG:   rd_val = {16'd0, DDR_MHZ, mem_gib};
      default:  rd_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (off)
      A_BUILD, A_CORECL, A_WRAPCL, A_SRST, A_MEMST, A_PCIEST,
      A_CLKGEN, A_BCFG, A_MCFG: wr_hit = 1'b1;
      default:                  wr_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      sys_reset_req <= 1'b0;
      unimpl_access <= 1'b0;
    end else begin
      rsp_valid     <= rd_req;
      rsp_rdata     <= (rd_req & word_ok) ? rd_val : '0;
      sys_reset_req <= wr_req & word_ok & (off == A_SRST) & req_wdata[RST_BIT];
      unimpl_access <= req_valid & (~word_ok | (req_write ? ~wr_hit : ~rd_hit));
    end
  end

  // R2: a read is answered in the next cycle
  p_read_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  // R2: no read data outside a response cycle
  p_quiet_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_rdata == 32'd0);
  // R3: a wrong-sized access yields zero data and no reset
  p_badsize_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd4) |=> (rsp_rdata == 32'd0 && !sys_reset_req && unimpl_access));
  // R10: a reset pulse only follows a qualifying write
  p_rst_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_write && req_size == 4'd4 && off == A_SRST)) |=> !sys_reset_req);
  // R6: memory status word is fixed
  p_memst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && word_ok && off == A_MEMST) |=> rsp_rdata == 32'h5);
  // R12: the debug flag never appears without a request
  p_flag_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !unimpl_access);
endmodule

// File: tb/plat_sysctl_regs_tb.sv
module plat_sysctl_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_size = 4'd4;
  logic [31:0] timer_hz = 32'd125000000;
  logic [3:0]  mem_gib = 4'd2;
  logic rsp_valid, sys_reset_req, unimpl_access;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  plat_sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .timer_hz(timer_hz), .mem_gib(mem_gib), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sys_reset_req(sys_reset_req), .unimpl_access(unimpl_access)
  );

  // tag[126:103] wr[102] addr[101:70] size[69:66] wdata[65:34] exp[33:2] rst[1] un[0]
  localparam int NV = 24;
  localparam logic [126:0] VEC [NV] = '{
    {"R5 ", 1'b0, 32'h00000000, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b0},
    {"R5 ", 1'b0, 32'h00000004, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b0},
    {"R5 ", 1'b0, 32'h00000008, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b0},
    {"R6 ", 1'b0, 32'h00000014, 4'd4, 32'h0, 32'h00000005, 1'b0, 1'b0},
    {"R7 ", 1'b0, 32'h00000030, 4'd4, 32'h0, 32'h01017D01, 1'b0, 1'b0},
    {"R8 ", 1'b0, 32'h00000034, 4'd4, 32'h0, 32'h0000000E, 1'b0, 1'b0},
    {"R9 ", 1'b0, 32'h00000038, 4'd4, 32'h0, 32'h0000FFF2, 1'b0, 1'b0},
    {"R4 ", 1'b0, 32'hABCD0014, 4'd4, 32'h0, 32'h00000005, 1'b0, 1'b0},
    {"R12", 1'b0, 32'h00000010, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b1},
    {"R12", 1'b0, 32'h0000001C, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b1},
    {"R12", 1'b0, 32'h00000048, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b1},
    {"R12", 1'b0, 32'h00000031, 4'd4, 32'h0, 32'h00000000, 1'b0, 1'b1},
    {"R3 ", 1'b0, 32'h00000014, 4'd2, 32'h0, 32'h00000000, 1'b0, 1'b1},
    {"R3 ", 1'b0, 32'h00000030, 4'd8, 32'h0, 32'h00000000, 1'b0, 1'b1},
    {"R10", 1'b1, 32'h00000010, 4'd4, 32'h00000010, 32'h0, 1'b1, 1'b0},
    {"R10", 1'b1, 32'h00000010, 4'd4, 32'hFFFFFFEF, 32'h0, 1'b0, 1'b0},
    {"R3 ", 1'b1, 32'h00000010, 4'd1, 32'h00000010, 32'h0, 1'b0, 1'b1},
    {"R11", 1'b1, 32'h00000014, 4'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b0},
    {"R11", 1'b1, 32'h00000030, 4'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b0},
    {"R12", 1'b1, 32'h00000024, 4'd4, 32'h00000010, 32'h0, 1'b0, 1'b1},
    {"R12", 1'b1, 32'h0000000C, 4'd4, 32'h00000010, 32'h0, 1'b0, 1'b1},
    {"R4 ", 1'b1, 32'h55550010, 4'd4, 32'h00000010, 32'h0, 1'b1, 1'b0},
    {"R11", 1'b0, 32'h00000014, 4'd4, 32'h0, 32'h00000005, 1'b0, 1'b0},
    {"R11", 1'b0, 32'h00000030, 4'd4, 32'h0, 32'h01017D01, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,rdata,rst,flag} actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one request on a falling edge, samples the response one period later.
  task automatic access(input logic wr, input logic [31:0] a, input logic [3:0] sz,
                        input logic [31:0] d, output logic [34:0] got);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    got = {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access};
    req_valid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 10000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [34:0] got;
    repeat (3) @(negedge clk);
    check("R1", {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access}, 35'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access}, 35'd0);

    for (int i = 0; i < NV; i++) begin
      logic [126:0] v;
      v = VEC[i];
      access(v[102], v[101:70], v[69:66], v[65:34], got);
      check(string'(v[126:103]), got, {~v[102], v[33:2], v[1], v[0]});
      @(negedge clk);
      // R2 R10 R12: all pulses gone in the following idle cycle
      check("R2", {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access}, 35'd0);
    end

    // R7: truncation of the MHz value
    timer_hz = 32'd99999999;
    access(1'b0, 32'h30, 4'd4, 32'h0, got);
    check("R7", got, {1'b1, 32'h01016301, 1'b0, 1'b0});
    timer_hz = 32'd300000000;
    access(1'b0, 32'h30, 4'd4, 32'h0, got);
    check("R7", got, {1'b1, 32'h01012C01, 1'b0, 1'b0});
    // R9: another memory size
    mem_gib = 4'd1;
    access(1'b0, 32'h38, 4'd4, 32'h0, got);
    check("R9", got, {1'b1, 32'h0000FFF1, 1'b0, 1'b0});

    // R10: back-to-back trigger then read gives one pulse then none
    access(1'b0, 32'h0, 4'd4, 32'h0, got);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h10; req_size = 4'd4; req_wdata = 32'h10;
    @(negedge clk);
    check("R10", {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access}, {1'b0, 32'h0, 1'b1, 1'b0});
    req_write = 1'b0; req_addr = 32'h14;
    @(negedge clk);
    check("R10", {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access}, {1'b1, 32'h5, 1'b0, 1'b0});
    req_valid = 1'b0;

    // R1: reset in the middle clears a pending response
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h30;
    rst_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {rsp_valid, rsp_rdata, sys_reset_req, unimpl_access}, 35'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule